// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines, keeps a pending flag for each, and gives each line a programmable 2-bit urgency value. A numerically smaller value is more urgent. Among the pending lines that are allowed to run, the controller picks the most urgent one. Ties go to the lowest line index. It raises a take request toward the processor only when that line outranks the handler that is running now.

When the processor accepts a take, the line's urgency becomes the running level. The level that was interrupted is pushed onto a small stack, one slot per urgency level. A handler-exit strobe pops the stack and brings the interrupted level back. With no handler running the level is idle, which ranks below all four urgency values. Two masks are available. A global disable bit blocks everything. A threshold value, when nonzero, blocks every line whose urgency value is equal to or larger than the threshold. Software reaches the urgency values and both masks through a simple write/read register port.

If an accept and a handler exit arrive in the same cycle, the accept is served and the exit is dropped.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every urgency value is 0, the threshold is 0, the global disable bit is 0, `take_req` is low and `run_level` is 4 (idle).
- R2: Register addresses 0..31 hold the urgency of the line with that index in data bits [1:0]. Address 32 holds the global disable in bit 0. Address 33 holds the threshold in bits [1:0]. Every other address reads as 0. Reads are combinational.
- R3: Among eligible pending lines, the one with the numerically smallest urgency value is offered on `take_vec`.
- R4: When several eligible pending lines share the smallest urgency value, the lowest index is offered.
- R5: A pending line is eligible only if its urgency value is strictly smaller than `run_level`. A line at a value equal to or larger than `run_level` waits.
- R6: In the cycle after an accept (`take_req` and `take_ack` both high), `take_req` is low and `run_level` equals the urgency of the accepted line.
- R7: A handler-exit strobe restores the level that was running before the most recent accept. Nesting reaches four handlers deep, and the level returns to idle (4) after the last exit.
- R8: While the global disable bit is 1, no take is raised. Lines stay pending and are offered once the bit is cleared.
- R9: A threshold of 0 has no effect. A nonzero threshold T blocks every line whose urgency value is T or larger.
- R10: A raised take stays high until it is accepted. Its vector changes only if an eligible line with a strictly smaller urgency value becomes pending.
- R11: A request pulse of one cycle is latched as pending. The pending flag is cleared by the accept of that vector.
- R12: A request that is present before clock edge k raises `take_req` after edge k+1 at the earliest, and no earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 32 | Level-sensitive request lines |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| take_req | output | 1 | Request to the processor to take an interrupt |
| take_vec | output | 5 | Vector index offered with `take_req` |
| take_ack | input | 1 | Processor accepts the offered vector |
| hexit | input | 1 | Handler-exit strobe |
| run_level | output | 3 | Running urgency level, 4 when idle |

## Verification
A wrong entry on the level stack shows up at `run_level` in the cycle after the exit strobe that pops it. It shows again one cycle later, when a line that should be blocked is offered, or one that should be offered is held back. A pending flag that is lost or left stuck becomes visible once the running level or the masks allow that line. That is either a missing take or an extra take during the drain that follows each scenario. A bad arbitration result appears on `take_vec` two edges after the request.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 2,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      irq_req,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic                    take_req,
  output logic [$clog2(NUM_SRC)-1:0] take_vec,
  input  logic                    take_ack,
  input  logic                    hexit,
  output logic [PRIO_W:0]         run_level
);
  localparam int LEVELS    = 1 << PRIO_W;
  localparam int VEC_W     = $clog2(NUM_SRC);
  localparam int LVL_W     = PRIO_W + 1;
  localparam int SP_W      = $clog2(LEVELS + 1);
  localparam logic [LVL_W-1:0]  IDLE      = LVL_W'(LEVELS);
  localparam logic [ADDR_W-1:0] ADDR_GDIS = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] ADDR_THR  = ADDR_W'(NUM_SRC + 1);

  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic              gdis_q;
  logic [PRIO_W-1:0] thr_q;
  logic [NUM_SRC-1:0] pend_q, elig, ack_mask;
  logic [LVL_W-1:0]  stack_q [LEVELS];
  logic [SP_W-1:0]   sp_q, sp_dec;
  logic              cand_ok, ack_go;
  logic [VEC_W-1:0]  cand_vec;
  logic [PRIO_W-1:0] cand_prio, held_prio;

  assign ack_go    = take_req & take_ack;
  assign held_prio = prio_q[take_vec];
  assign ack_mask  = ack_go ? (NUM_SRC'(1) << take_vec) : '0;
  assign sp_dec    = sp_q - SP_W'(1);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = pend_q[i] && !gdis_q
                   && ({1'b0, prio_q[i]} < run_level)
                   && (thr_q == '0 || prio_q[i] < thr_q);
  end

  always_comb begin
    cand_ok   = 1'b0;
    cand_vec  = '0;
    cand_prio = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!cand_ok || prio_q[i] < cand_prio)) begin
        cand_ok   = 1'b1;
        cand_vec  = VEC_W'(i);
        cand_prio = prio_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
      gdis_q <= 1'b0;
      thr_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr < ADDR_W'(NUM_SRC))
        prio_q[reg_addr[VEC_W-1:0]] <= reg_wdata[PRIO_W-1:0];
      else if (reg_addr == ADDR_GDIS)
        gdis_q <= reg_wdata[0];
      else if (reg_addr == ADDR_THR)
        thr_q <= reg_wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADDR_W'(NUM_SRC))
      reg_rdata = DATA_W'(prio_q[reg_addr[VEC_W-1:0]]);
    else if (reg_addr == ADDR_GDIS)
      reg_rdata = DATA_W'(gdis_q);
    else if (reg_addr == ADDR_THR)
      reg_rdata = DATA_W'(thr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | irq_req) & ~ack_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_req <= 1'b0;
      take_vec <= '0;
    end else if (ack_go) begin
      take_req <= 1'b0;
    end else if (!take_req && cand_ok) begin
      take_req <= 1'b1;
      take_vec <= cand_vec;
    end else if (take_req && cand_ok && cand_prio < held_prio) begin
      take_vec <= cand_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_level <= IDLE;
      sp_q      <= '0;
      for (int i = 0; i < LEVELS; i++) stack_q[i] <= IDLE;
    end else if (ack_go) begin
      stack_q[sp_q[PRIO_W-1:0]] <= run_level;
      sp_q      <= sp_q + SP_W'(1);
      run_level <= {1'b0, held_prio};
    end else if (hexit && sp_q != '0) begin
      run_level <= stack_q[sp_dec[PRIO_W-1:0]];
      sp_q      <= sp_dec;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int PRIO_W = 2,
  parameter int VEC_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take_req,
  input logic              take_ack,
  input logic [VEC_W-1:0]  take_vec,
  input logic              hexit,
  input logic [PRIO_W:0]   run_level,
  input logic [PRIO_W-1:0] held_prio,
  input logic              gdis_q,
  input logic [PRIO_W-1:0] thr_q
);
  localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(1 << PRIO_W);

  p_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_req) |-> ({1'b0, held_prio} < $past(run_level)));

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && take_ack) |=> (!take_req && run_level < $past(run_level)));

  p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hexit && !take_ack && run_level != IDLE) |=> (run_level > $past(run_level)));

  p_gdis_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_req) |-> !$past(gdis_q));

  p_thr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_req) |-> ($past(thr_q) == '0 || held_prio < $past(thr_q)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && !take_ack) |=> take_req);

  p_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && !take_ack) |=> (take_vec == $past(take_vec) || held_prio < $past(held_prio)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.PRIO_W(PRIO_W), .VEC_W($clog2(NUM_SRC))) u_chk (
  .clk(clk), .rst_n(rst_n), .take_req(take_req), .take_ack(take_ack),
  .take_vec(take_vec), .hexit(hexit), .run_level(run_level),
  .held_prio(held_prio), .gdis_q(gdis_q), .thr_q(thr_q));

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_req = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        take_req;
  logic [4:0]  take_vec;
  logic        take_ack = 1'b0;
  logic        hexit = 1'b0;
  logic [2:0]  run_level;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u0 (.*);

  // table entry: {request mask, expected vector}; urgency of line i is 3 - (i % 4)
  localparam logic [36:0] TBL [8] = '{
    {32'h0000_0020, 5'd5},  {32'h0000_0003, 5'd1},
    {32'h0000_0110, 5'd4},  {32'h0000_0088, 5'd3},
    {32'h8000_0004, 5'd31}, {32'h4000_0240, 5'd6},
    {32'h0001_3000, 5'd13}, {32'hFFFF_FFFF, 5'd3}};

  function automatic int urg(int i); return 3 - (i % 4); endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    reg_addr = 6'(a); #1;
    chk(reg_rdata == 8'(exp), tag, reg_rdata, exp);
  endtask

  task automatic raise(int s);
    irq_req[s] = 1'b1;
    @(negedge clk); irq_req = '0;
    @(negedge clk);
  endtask

  task automatic ack();
    take_ack = 1'b1; @(negedge clk); take_ack = 1'b0;
  endtask

  task automatic hx();
    hexit = 1'b1; @(negedge clk); hexit = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (take_req) begin ack(); hx(); end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!take_req, "R1 take_req", take_req, 0);
    chk(run_level == 3'd4, "R1 run_level", run_level, 4);
    rd(5, 0, "R1 urgency");
    rd(32, 0, "R1 gdis");
    rd(33, 0, "R1 thr");

    for (int i = 0; i < 32; i++) wr(i, urg(i));
    rd(2, 1, "R2 urgency line 2");
    rd(31, 0, "R2 urgency line 31");
    rd(40, 0, "R2 unmapped");

    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      irq_req = TBL[e][36:5];
      @(negedge clk);
      irq_req = '0;
      chk(!take_req, "R12 early take", take_req, 0);
      @(negedge clk);
      chk(take_req, "R11 R12 take raised", take_req, 1);
      chk(take_vec == TBL[e][4:0], "R3 R4 vector", take_vec, TBL[e][4:0]);
      ack();
      chk(!take_req && run_level == 3'(urg(TBL[e][4:0])), "R6 level after accept",
          run_level, urg(TBL[e][4:0]));
      hx();
      chk(run_level == 3'd4, "R7 idle after exit", run_level, 4);
      drain();
    end

    // nesting four deep, equal level waits
    raise(0);
    chk(take_req && take_vec == 0, "R5 take line 0", take_vec, 0);
    ack();
    chk(run_level == 3, "R6 level 3", run_level, 3);
    raise(4);
    @(negedge clk); @(negedge clk);
    chk(!take_req, "R5 equal level waits", take_req, 0);
    raise(1);
    chk(take_req && take_vec == 1, "R5 preempt line 1", take_vec, 1);
    ack();
    raise(2); ack();
    raise(3);
    chk(take_req && take_vec == 3, "R5 preempt line 3", take_vec, 3);
    ack();
    chk(run_level == 0, "R7 depth four", run_level, 0);
    hx(); chk(run_level == 1, "R7 pop to 1", run_level, 1);
    hx(); chk(run_level == 2, "R7 pop to 2", run_level, 2);
    hx(); chk(run_level == 3, "R7 pop to 3", run_level, 3);
    chk(!take_req, "R5 line 4 still waits", take_req, 0);
    hx(); chk(run_level == 4, "R7 pop to idle", run_level, 4);
    @(negedge clk);
    chk(take_req && take_vec == 4, "R11 waiting line offered", take_vec, 4);
    drain();

    // held take stability and switch
    raise(0);
    chk(take_req && take_vec == 0, "R10 take line 0", take_vec, 0);
    raise(8);
    chk(take_req && take_vec == 0, "R10 stable on equal", take_vec, 0);
    raise(3);
    chk(take_req && take_vec == 3, "R10 switch to urgent", take_vec, 3);
    drain();

    // global disable
    wr(32, 1);
    rd(32, 1, "R2 gdis readback");
    raise(3);
    @(negedge clk); @(negedge clk);
    chk(!take_req, "R8 blocked", take_req, 0);
    wr(32, 0);
    @(negedge clk);
    chk(take_req && take_vec == 3, "R8 released", take_vec, 3);
    drain();

    // threshold
    wr(33, 2);
    rd(33, 2, "R2 thr readback");
    raise(1);
    @(negedge clk);
    chk(!take_req, "R9 value at threshold blocked", take_req, 0);
    raise(2);
    chk(take_req && take_vec == 2, "R9 below threshold passes", take_vec, 2);
    drain();
    chk(!take_req, "R9 line 1 still blocked", take_req, 0);
    wr(33, 0);
    @(negedge clk);
    chk(take_req && take_vec == 1, "R9 zero threshold", take_vec, 1);
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule